// File: doc/BRIEF.md
# Serial SAR Converter Output Model

This block models the digital face of a 16-bit successive-approximation converter with a three-wire serial port. It is meant to be the device under test for an SPI master running with clock polarity 0 and phase 0. A parallel word, `sample_in`, stands in for the analog input that is being held. The block does not model analog error or pad timing. It reproduces the framing the master must cope with:

- the point at which acquisition closes,
- the leading zero bits,
- the result sent MSB first,
- the zero fill when the master clocks past the end of the frame,
- the abort to shutdown when chip select is released early.

Chip select and serial clock are asynchronous to the block. Each passes through a flop synchronizer in the system clock domain, and edges are detected there. A frame-control state machine has four states:

| State | Status code | Meaning |
|---|---|---|
| OFF | `00` | shutdown |
| ACQ | `01` | acquiring |
| CONV | `10` | converting and shifting |
| TAIL | `11` | frame complete |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| wake | OFF | ACQ | chip-select falling edge |
| hold | ACQ | CONV | sixth falling serial-clock edge; the sample is captured here |
| finish | CONV | TAIL | 24th falling edge |
| abort / release | any | OFF | synchronized chip select is high |

In TAIL, extra clocks shift out zeros. A bit counter saturates at the frame length.

Top module: `serial_adc_model`

## Requirements
- R1: After reset `sdo_oe` is 0, `sdo` is high impedance and `status` is `00`.
- R2: A falling edge of `cs_n` enables the output, which is driven 0, and moves `status` to `01`.
- R3: After the falling serial-clock edges 1 to 7 of a frame, `sdo` is 0.
- R4: `sdo` changes only after a falling edge of `sclk`, and a rising edge leaves it unchanged.
- R5: The word captured is the value of `sample_in` at the sixth falling edge. Changes before that edge are taken, and changes after it are ignored.
- R6: After falling edge 8+i (i = 0..15), `sdo` carries result bit 15-i. The result is straight binary, so `sample_in` 0x0000 gives all zero bits and 0xFFFF gives all one bits.
- R7: After falling edge 24, and for any number of further edges, `sdo` is 0 and `status` stays `11`.
- R8: `cs_n` held high disables the output and returns `status` to `00`.
- R9: Raising `cs_n` before edge 24 aborts the frame. The next falling edge of `cs_n` starts a fresh frame from edge count zero with a newly captured word.
- R10: `status` is `01` for edge counts 0 to 5, `10` for counts 6 to 23, and `11` at 24.
- R11: A change on `cs_n` reaches the outputs after exactly three system-clock edges: two synchronizer flops and the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| sample_in | input | DATA_W | Parallel word standing in for the held input |
| sdo | output | 1 | Serial data, high impedance when disabled |
| sdo_oe | output | 1 | High while `sdo` is driven |
| status | output | 2 | 00 shutdown, 01 acquiring, 10 converting, 11 complete |

## Verification
The bench sweeps many result words:

- 0x0000 and 0xFFFF,
- a walking one across every bit,
- a walking zero,
- arithmetic patterns.

Each frame checks every bit position against the word. Off-by-one slips are the main target: a design that counted the first result edge wrongly would shift the whole word by a bit. A design that captured at chip select would send the junk value present at that moment. A design that captured late would send the inverted word that the bench applies straight after edge six.

Long trailing runs catch a counter that wraps and starts sending the result again. An abort after ten edges, followed by a full frame, catches state left over from the aborted conversion. Checks after each rising `sclk` edge catch data that moves on the wrong edge.

// File: rtl/adc_model_pkg.sv
package adc_model_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_ACQ  = 2'b01,
        ST_CONV = 2'b10,
        ST_TAIL = 2'b11
    } frame_state_t;

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_VAL}};
            prev  <= IDLE_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_model_pkg::*;
#(
    parameter int LEAD_ZEROS = 8,
    parameter int ACQ_EDGES  = 6,
    parameter int FRAME_LEN  = 24,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output frame_state_t     state,
    output logic [CNT_W-1:0] edge_cnt,
    output logic             load_en,
    output logic             shift_en,
    output logic             clear
);
    localparam logic [CNT_W:0]   LEAD_C  = (CNT_W+1)'(LEAD_ZEROS);
    localparam logic [CNT_W:0]   ACQ_C   = (CNT_W+1)'(ACQ_EDGES);
    localparam logic [CNT_W:0]   FRAME_C = (CNT_W+1)'(FRAME_LEN);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(FRAME_LEN);

    frame_state_t    state_nx;
    logic [CNT_W:0]  cnt_inc;

    assign cnt_inc = {1'b0, edge_cnt} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_hi) begin
            state_nx = ST_OFF;                       // abort / release
        end else begin
            unique case (state)
                ST_OFF:  if (cs_fall) state_nx = ST_ACQ;                        // wake
                ST_ACQ:  if (sclk_fall && cnt_inc == ACQ_C) state_nx = ST_CONV;  // hold
                ST_CONV: if (sclk_fall && cnt_inc == FRAME_C) state_nx = ST_TAIL; // finish
                ST_TAIL: state_nx = ST_TAIL;
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // output strobes
    always_comb begin
        clear    = cs_hi || (state == ST_OFF);
        load_en  = 1'b0;
        shift_en = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_ACQ:  load_en  = sclk_fall && !cs_hi && (cnt_inc == ACQ_C);
            ST_CONV,
            ST_TAIL: shift_en = sclk_fall && !cs_hi && (cnt_inc >= LEAD_C);
            default: ;
        endcase
    end

    // saturating edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              edge_cnt <= '0;
        else if (clear)                          edge_cnt <= '0;
        else if (sclk_fall && edge_cnt != SAT_C) edge_cnt <= edge_cnt + 1'b1;
    end
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] sample,
    output logic              sdo_q
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo_q <= 1'b0;
        end else if (clear) begin
            shreg <= '0;
            sdo_q <= 1'b0;
        end else if (load_en) begin
            shreg <= sample;
        end else if (shift_en) begin
            sdo_q <= shreg[DATA_W-1];
            shreg <= {shreg[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/serial_adc_model.sv
module serial_adc_model
    import adc_model_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LEAD_ZEROS  = 8,
    parameter int ACQ_EDGES   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        status
);
    localparam int FRAME_LEN = LEAD_ZEROS + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic             cs_lvl, cs_fall, sclk_lvl, sclk_fall;
    logic             load_en, shift_en, clear, sdo_q;
    logic [CNT_W-1:0] edge_cnt;
    frame_state_t     state;

    adc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_lvl), .fall(cs_fall)
    );

    adc_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .level(sclk_lvl), .fall(sclk_fall)
    );

    adc_frame_fsm #(
        .LEAD_ZEROS(LEAD_ZEROS), .ACQ_EDGES(ACQ_EDGES),
        .FRAME_LEN(FRAME_LEN),   .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_lvl), .cs_fall(cs_fall),
        .sclk_fall(sclk_fall), .state(state), .edge_cnt(edge_cnt),
        .load_en(load_en), .shift_en(shift_en), .clear(clear)
    );

    adc_shift_out #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(clear), .load_en(load_en),
        .shift_en(shift_en), .sample(sample_in), .sdo_q(sdo_q)
    );

    assign sdo_oe = (state != ST_OFF);
    assign status = state;
    assign sdo    = sdo_oe ? sdo_q : 1'bz;
endmodule

// File: rtl/adc_model_checker.sv
module adc_model_checker #(
    parameter int ACQ_EDGES = 6,
    parameter int FRAME_LEN = 24,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sdo_oe,
    input logic [1:0]       status,
    input logic             sdo_q,
    input logic             shift_en,
    input logic             load_en,
    input logic             clear,
    input logic             cs_fall,
    input logic             sclk_lvl,
    input logic [CNT_W-1:0] edge_cnt
);
    assert_wake_needs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(cs_fall));

    assert_sdo_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_q != $past(sdo_q)) |-> ($past(shift_en) || $past(clear)));

    assert_shift_when_sclk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> !sclk_lvl);

    assert_load_at_sixth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (status == 2'b10 && edge_cnt == CNT_W'(ACQ_EDGES)));

    assert_tail_saturated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11) |-> (edge_cnt == CNT_W'(FRAME_LEN)));

    assert_tail_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11) |=> (status == 2'b11 || status == 2'b00));

    assert_cs_high_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !sdo_oe);

    assert_off_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) == 2'b00) |-> (status == 2'b00 || status == 2'b01));
endmodule

bind serial_adc_model adc_model_checker #(
    .ACQ_EDGES(ACQ_EDGES), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .status(status),
    .sdo_q(sdo_q), .shift_en(shift_en), .load_en(load_en), .clear(clear),
    .cs_fall(cs_fall), .sclk_lvl(sclk_lvl), .edge_cnt(edge_cnt)
);

// File: tb/serial_adc_model_tb.sv
`timescale 1ns/1ps
module serial_adc_model_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [15:0] sample_in = '0;
    wire         sdo;
    wire         sdo_oe;
    wire  [1:0]  status;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    serial_adc_model u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .status(status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_frame(input logic [15:0] word, input int edges, input bit release_cs);
        logic prev;
        logic exp_bit;
        logic [1:0] exp_st;
        sample_in = word ^ 16'h5A5A;
        cs_n = 1'b0;
        tick(2);
        chk(sdo_oe, 0, "R11 not yet enabled");
        tick(1);
        chk(sdo_oe, 1, "R11 enabled after three edges");
        tick(2);
        chk(status, 2'b01, "R2 status acquiring");
        chk(sdo, 0, "R2 driven low");
        prev = 1'b0;
        for (int e = 1; e <= edges; e++) begin
            if (e == 3) sample_in = word;
            sclk = 1'b1;
            tick(HALF);
            chk(sdo, prev, "R4 rising edge no change");
            sclk = 1'b0;
            tick(HALF);
            if (e < 8)       exp_bit = 1'b0;
            else if (e < 24) exp_bit = word[23-e];
            else             exp_bit = 1'b0;
            if (e < 8)       chk(sdo, exp_bit, "R3 leading zero");
            else if (e < 24) chk(sdo, exp_bit, "R6 R5 result bit");
            else             chk(sdo, exp_bit, "R7 trailing zero");
            if (e < 6)       exp_st = 2'b01;
            else if (e < 24) exp_st = 2'b10;
            else             exp_st = 2'b11;
            chk(status, exp_st, "R10 status code");
            if (e == 6) sample_in = ~word;
            prev = exp_bit;
        end
        if (release_cs) begin
            cs_n = 1'b1;
            tick(5);
            chk(sdo_oe, 0, "R8 output disabled");
            chk(status, 2'b00, "R8 shutdown status");
            tick(2);
        end
    endtask

    initial begin
        tick(5);
        chk(sdo_oe, 0, "R1 reset disabled");
        chk(status, 2'b00, "R1 reset status");
        rst_n = 1'b1;
        tick(4);
        chk(sdo_oe, 0, "R1 idle disabled");
        run_frame(16'h0000, 24, 1'b1);
        run_frame(16'hFFFF, 24, 1'b1);
        for (int b = 0; b < 16; b++) run_frame(16'(1) << b, 24, 1'b1);
        for (int b = 0; b < 16; b += 3) run_frame(~(16'(1) << b), 24, 1'b1);
        for (int k = 1; k < 6; k++) run_frame(16'(k * 16'h9E37), 24, 1'b1);
        run_frame(16'hA5C3, 40, 1'b1);        // R7 long trailing run
        run_frame(16'h1234, 10, 1'b0);        // R9 abort mid-frame
        cs_n = 1'b1;
        tick(2);
        chk(sdo_oe, 1, "R11 abort not yet seen");
        tick(3);
        chk(sdo_oe, 0, "R9 abort disables output");
        chk(status, 2'b00, "R9 abort shutdown");
        tick(2);
        run_frame(16'hC0DE, 26, 1'b1);        // R9 fresh frame after abort
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule